// File: doc/BRIEF.md
# DDR3 Power-Up Command Sequencer

This block brings a DDR3 device out of power-up and through read-gate training with no processor involvement. After a start pulse it walks a fixed list of direct memory commands. Each command is built as a 32-bit word and offered on a command port. The port acknowledges completion with a one-cycle done strobe. The list covers a deselect followed by a short idle gap, a precharge-all, four mode-register writes taken from its inputs, and a long ZQ calibration.

It then runs gate training. First it parks the auto-refresh interval at zero and raises a training-start control. It waits for both byte lanes to report completion. It then issues three catch-up refreshes and finally puts the saved interval back. A done flag marks the end of the run. A command that is never acknowledged within a bounded number of cycles halts the run and raises an error flag instead.

Top module: `ddr3_boot_seq`

## Requirements
- R1: Each command word has bit 31 set as the start flag, both rank-select bits 21:20 set to 1, the bank in bits 19:17, the 13-bit address in bits 16:4 and the opcode in bits 3:0. The opcodes are deselect 0, precharge-all 1, refresh 2, mode-register write 3, short ZQ 4, long ZQ 5, reset-low 6 and mode-register read 8. The word reads zero whenever no command is offered.
- R2: The accepted commands of one run are, in order: deselect; precharge-all; mode-register write to bank 2 with mr2Val; to bank 3 with mr3Val; to bank 1 with mr1Val; to bank 0 with mr0Val and address bit 8 forced to 1; long ZQ; then, after training, three refreshes. All address and bank fields not named here are zero.
- R3: A command stays offered, with its word unchanged, until cmdDone is seen high together with cmdValid. Each command is accepted exactly once. Consecutive commands (other than around the gap and training) are offered back to back.
- R4: Between acceptance of the deselect and the offer of precharge-all, cmdValid is low for exactly DESEL_GAP cycles.
- R5: trainStart rises in the cycle after the long ZQ is accepted. It stays high until trainDone reads 2'b11, and a single lane bit does not end it. No command is offered while it is high.
- R6: refiOut follows refiIn one cycle late while idle, while halted and during the commands up to the long ZQ. It is zero from training start through the last refresh. After that it holds the refiIn value sampled on the long-ZQ acceptance cycle until the next start.
- R7: If cmdDone does not arrive within TOUT_CYC consecutive offer cycles of one command, seqErr rises, cmdValid drops and the run halts. An acknowledge in the TOUT_CYC-th cycle is still accepted.
- R8: seqDone rises after the interval is restored. It stays high until a start pulse or reset.
- R9: A start pulse during a run is ignored. A start pulse while done or halted begins a new run from deselect and clears both flags in the next cycle.
- R10: During reset, cmdValid, cmdWord, trainStart, seqDone, seqErr and refiOut are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a run when idle, done or halted |
| mr0Val | input | 13 | Mode-register 0 content |
| mr1Val | input | 13 | Mode-register 1 content |
| mr2Val | input | 13 | Mode-register 2 content |
| mr3Val | input | 13 | Mode-register 3 content |
| cmdDone | input | 1 | Command port completion strobe |
| trainDone | input | 2 | Training complete per byte lane (high, low) |
| refiIn | input | 16 | Programmed refresh interval |
| cmdWord | output | 32 | Command word |
| cmdValid | output | 1 | Command word offered |
| trainStart | output | 1 | Training start control |
| refiOut | output | 16 | Refresh interval driven to the controller |
| seqDone | output | 1 | Run complete |
| seqErr | output | 1 | Run halted on a missing acknowledge |

## Verification
The two events that can fall in the same cycle are a command acknowledge and the expiry of the timeout counter. The bench sweeps the port latency over every value from zero up to one past the limit. At latency TOUT_CYC-1 the acknowledge lands in exactly the cycle in which the counter reaches its last count. There the acknowledge must win: the run must still finish with all ten words correct and no error. One cycle more of latency must instead halt the run after exactly TOUT_CYC offer cycles.

// File: rtl/ddr3_boot_pkg.sv
package ddr3_boot_pkg;

  localparam int CMD_W       = 32;
  localparam int START_BIT   = 31;
  localparam int RANK_LSB    = 20;
  localparam int BANK_LSB    = 17;
  localparam int ADDR_LSB    = 4;
  localparam int OP_W        = 4;
  localparam int DLL_RST_BIT = 8;
  localparam int STEP_W      = 4;

  // step numbers of the command list
  localparam logic [STEP_W-1:0] STEP_DESEL = 4'd0;
  localparam logic [STEP_W-1:0] STEP_PREA  = 4'd1;
  localparam logic [STEP_W-1:0] STEP_MRA   = 4'd2;
  localparam logic [STEP_W-1:0] STEP_MRD   = 4'd5;
  localparam logic [STEP_W-1:0] STEP_ZQCL  = 4'd6;
  localparam logic [STEP_W-1:0] STEP_LAST  = 4'd9;

  typedef enum logic [OP_W-1:0] {
    OP_DESEL = 4'd0,
    OP_PREA  = 4'd1,
    OP_REF   = 4'd2,
    OP_MRS   = 4'd3,
    OP_ZQCS  = 4'd4,
    OP_ZQCL  = 4'd5,
    OP_RSTL  = 4'd6,
    OP_MRR   = 4'd8
  } cmdOp_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_GAP,
    ST_TRAIN,
    ST_FIN,
    ST_FAULT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stepClr;
    logic stepInc;
    logic gapLoad;
    logic gapDec;
    logic toutClr;
    logic toutInc;
    logic refiSave;
    logic refiRestore;
    logic refiTrack;
  } dpCtl_t;

  // mode-register steps 2..5 target banks 2,3,1,0
  function automatic logic [1:0] mrBank(input logic [STEP_W-1:0] step);
    case (step)
      4'd2:    mrBank = 2'd2;
      4'd3:    mrBank = 2'd3;
      4'd4:    mrBank = 2'd1;
      default: mrBank = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ddr3_boot_dp.sv
module ddr3_boot_dp
  import ddr3_boot_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BANK_W    = 3,
  parameter int RANK_W    = 2,
  parameter int REFI_W    = 16,
  parameter int DESEL_GAP = 16,
  parameter int TOUT_CYC  = 1024
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  input  logic [3:0][ADDR_W-1:0]    mrSet,
  input  logic [REFI_W-1:0]         refiIn,
  output logic [STEP_W-1:0]         stepIdx,
  output logic                      gapZero,
  output logic                      toutLast,
  output logic [CMD_W-1:0]          wordRaw,
  output logic [REFI_W-1:0]         refiOut
);

  localparam int GAP_W  = $clog2(DESEL_GAP + 1);
  localparam int TOUT_W = $clog2(TOUT_CYC + 1);

  logic [GAP_W-1:0]  gapCnt;
  logic [TOUT_W-1:0] toutCnt;
  logic [REFI_W-1:0] savedRefi;

  // step pointer
  always_ff @(posedge clk) begin
    if (!rstN)            stepIdx <= '0;
    else if (ctl.stepClr) stepIdx <= '0;
    else if (ctl.stepInc) stepIdx <= stepIdx + 1'b1;
  end

  // idle gap after the deselect
  always_ff @(posedge clk) begin
    if (!rstN)            gapCnt <= '0;
    else if (ctl.gapLoad) gapCnt <= GAP_W'(DESEL_GAP - 1);
    else if (ctl.gapDec)  gapCnt <= gapCnt - 1'b1;
  end
  assign gapZero = (gapCnt == '0);

  // acknowledge timeout
  always_ff @(posedge clk) begin
    if (!rstN)            toutCnt <= '0;
    else if (ctl.toutClr) toutCnt <= '0;
    else if (ctl.toutInc) toutCnt <= toutCnt + 1'b1;
  end
  assign toutLast = (toutCnt == TOUT_W'(TOUT_CYC - 1));

  // refresh interval override
  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedRefi <= '0;
      refiOut   <= '0;
    end else if (ctl.refiSave) begin
      savedRefi <= refiIn;
      refiOut   <= '0;
    end else if (ctl.refiRestore) begin
      refiOut   <= savedRefi;
    end else if (ctl.refiTrack) begin
      refiOut   <= refiIn;
    end
  end

  // command word builder
  cmdOp_t             opSel;
  logic [BANK_W-1:0]  bankSel;
  logic [ADDR_W-1:0]  addrSel;

  always_comb begin
    opSel   = OP_DESEL;
    bankSel = '0;
    addrSel = '0;
    if (stepIdx == STEP_PREA) begin
      opSel = OP_PREA;
    end else if (stepIdx >= STEP_MRA && stepIdx <= STEP_MRD) begin
      opSel   = OP_MRS;
      bankSel = BANK_W'(mrBank(stepIdx));
      addrSel = mrSet[mrBank(stepIdx)];
      if (stepIdx == STEP_MRD) addrSel[DLL_RST_BIT] = 1'b1;
    end else if (stepIdx == STEP_ZQCL) begin
      opSel = OP_ZQCL;
    end else if (stepIdx > STEP_ZQCL) begin
      opSel = OP_REF;
    end
  end

  always_comb begin
    wordRaw                          = '0;
    wordRaw[START_BIT]               = 1'b1;
    wordRaw[RANK_LSB +: RANK_W]      = '1;
    wordRaw[BANK_LSB +: BANK_W]      = bankSel;
    wordRaw[ADDR_LSB +: ADDR_W]      = addrSel;
    wordRaw[OP_W-1:0]                = opSel;
  end

endmodule

// File: rtl/ddr3_boot_ctl.sv
module ddr3_boot_ctl
  import ddr3_boot_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               cmdDone,
  input  logic [1:0]         trainDone,
  input  logic [STEP_W-1:0]  stepIdx,
  input  logic               gapZero,
  input  logic               toutLast,
  output dpCtl_t             ctl,
  output logic               cmdValid,
  output logic               trainStart,
  output logic               seqDone,
  output logic               seqErr
);

  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl        = '0;
    nxt        = state;
    cmdValid   = 1'b0;
    trainStart = 1'b0;
    seqDone    = 1'b0;
    seqErr     = 1'b0;
    case (state)
      ST_IDLE, ST_FIN, ST_FAULT: begin
        seqDone       = (state == ST_FIN);
        seqErr        = (state == ST_FAULT);
        ctl.refiTrack = (state != ST_FIN) || startPulse;
        if (startPulse) begin
          nxt         = ST_SEND;
          ctl.stepClr = 1'b1;
          ctl.toutClr = 1'b1;
        end
      end
      ST_SEND: begin
        cmdValid      = 1'b1;
        ctl.refiTrack = (stepIdx <= STEP_ZQCL);
        if (cmdDone) begin
          ctl.toutClr = 1'b1;
          if (stepIdx == STEP_DESEL) begin
            nxt         = ST_GAP;
            ctl.gapLoad = 1'b1;
          end else if (stepIdx == STEP_ZQCL) begin
            nxt          = ST_TRAIN;
            ctl.refiSave = 1'b1;
            ctl.stepInc  = 1'b1;
          end else if (stepIdx == STEP_LAST) begin
            nxt             = ST_FIN;
            ctl.refiRestore = 1'b1;
          end else begin
            ctl.stepInc = 1'b1;
          end
        end else if (toutLast) begin
          nxt = ST_FAULT;
        end else begin
          ctl.toutInc = 1'b1;
        end
      end
      ST_GAP: begin
        if (gapZero) begin
          nxt         = ST_SEND;
          ctl.stepInc = 1'b1;
        end else begin
          ctl.gapDec = 1'b1;
        end
      end
      ST_TRAIN: begin
        trainStart = 1'b1;
        if (trainDone == 2'b11) nxt = ST_SEND;
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ddr3_boot_seq.sv
module ddr3_boot_seq
  import ddr3_boot_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BANK_W    = 3,
  parameter int RANK_W    = 2,
  parameter int REFI_W    = 16,
  parameter int DESEL_GAP = 16,
  parameter int TOUT_CYC  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] mr0Val,
  input  logic [ADDR_W-1:0] mr1Val,
  input  logic [ADDR_W-1:0] mr2Val,
  input  logic [ADDR_W-1:0] mr3Val,
  input  logic              cmdDone,
  input  logic [1:0]        trainDone,
  input  logic [REFI_W-1:0] refiIn,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              cmdValid,
  output logic              trainStart,
  output logic [REFI_W-1:0] refiOut,
  output logic              seqDone,
  output logic              seqErr
);

  dpCtl_t              ctl;
  logic [STEP_W-1:0]   stepIdx;
  logic                gapZero;
  logic                toutLast;
  logic [CMD_W-1:0]    wordRaw;
  logic [3:0][ADDR_W-1:0] mrSet;

  assign mrSet = {mr3Val, mr2Val, mr1Val, mr0Val};

  ddr3_boot_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .cmdDone    (cmdDone),
    .trainDone  (trainDone),
    .stepIdx    (stepIdx),
    .gapZero    (gapZero),
    .toutLast   (toutLast),
    .ctl        (ctl),
    .cmdValid   (cmdValid),
    .trainStart (trainStart),
    .seqDone    (seqDone),
    .seqErr     (seqErr)
  );

  ddr3_boot_dp #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .RANK_W    (RANK_W),
    .REFI_W    (REFI_W),
    .DESEL_GAP (DESEL_GAP),
    .TOUT_CYC  (TOUT_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .mrSet    (mrSet),
    .refiIn   (refiIn),
    .stepIdx  (stepIdx),
    .gapZero  (gapZero),
    .toutLast (toutLast),
    .wordRaw  (wordRaw),
    .refiOut  (refiOut)
  );

  assign cmdWord = cmdValid ? wordRaw : '0;

endmodule

// File: rtl/ddr3_boot_chk.sv
module ddr3_boot_chk #(
  parameter int ADDR_W = 13,
  parameter int REFI_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic [ADDR_W-1:0] mr0Val,
  input logic [ADDR_W-1:0] mr1Val,
  input logic [ADDR_W-1:0] mr2Val,
  input logic [ADDR_W-1:0] mr3Val,
  input logic              cmdDone,
  input logic [1:0]        trainDone,
  input logic [REFI_W-1:0] refiIn,
  input logic [31:0]       cmdWord,
  input logic              cmdValid,
  input logic              trainStart,
  input logic [REFI_W-1:0] refiOut,
  input logic              seqDone,
  input logic              seqErr
);

  assert_start_rank_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdWord[31] && cmdWord[21:20] == 2'b11));

  assert_word_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdDone && !seqErr) |=> (seqErr || (cmdValid && $stable(cmdWord))));

  assert_quiet_train_R5: assert property (@(posedge clk) disable iff (!rstN)
    trainStart |-> !cmdValid);

  assert_train_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (trainStart && trainDone != 2'b11) |=> trainStart);

  assert_refi_parked_R6: assert property (@(posedge clk) disable iff (!rstN)
    trainStart |-> (refiOut == '0));

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |-> (!cmdValid && !trainStart && !seqDone));

  assert_done_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && !startPulse) |=> seqDone);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (!cmdValid && !trainStart));

endmodule

bind ddr3_boot_seq ddr3_boot_chk #(.ADDR_W(ADDR_W), .REFI_W(REFI_W)) u_chk (.*);

// File: tb/sim_ddr3_boot_seq.sv
`timescale 1ns/1ps
module sim_ddr3_boot_seq;

  localparam int GAP  = 4;
  localparam int TOUT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [12:0] mr0Val = '0, mr1Val = '0, mr2Val = '0, mr3Val = '0;
  logic        cmdDone;
  logic [1:0]  trainDone = 2'b00;
  logic [15:0] refiIn = '0;
  logic [31:0] cmdWord;
  logic        cmdValid, trainStart, seqDone, seqErr;
  logic [15:0] refiOut;

  int checks = 0;
  int errors = 0;
  int portLat = 0;
  int waitCnt = 0;
  int logN = 0;
  bit finished = 0;
  logic [31:0] wlog [0:255];

  always #2.5 clk = ~clk;

  ddr3_boot_seq #(.DESEL_GAP(GAP), .TOUT_CYC(TOUT)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .mr0Val(mr0Val), .mr1Val(mr1Val), .mr2Val(mr2Val), .mr3Val(mr3Val),
    .cmdDone(cmdDone), .trainDone(trainDone), .refiIn(refiIn),
    .cmdWord(cmdWord), .cmdValid(cmdValid), .trainStart(trainStart),
    .refiOut(refiOut), .seqDone(seqDone), .seqErr(seqErr)
  );

  // command port model: acknowledge on the (portLat+1)-th offer cycle
  always @(negedge clk) begin
    cmdDone = 1'b0;
    if (rstN && cmdValid) begin
      if (waitCnt == portLat) begin
        cmdDone = 1'b1;
        if (logN < 256) wlog[logN] = cmdWord;
        logN++;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end else begin
      waitCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int idx, input logic [12:0] m0,
      input logic [12:0] m1, input logic [12:0] m2, input logic [12:0] m3);
    longint op, bank, addr, w;
    op = 2; bank = 0; addr = 0;
    case (idx)
      0: op = 0;
      1: op = 1;
      2: begin op = 3; bank = 2; addr = m2; end
      3: begin op = 3; bank = 3; addr = m3; end
      4: begin op = 3; bank = 1; addr = m1; end
      5: begin op = 3; bank = 0; addr = m0 | 13'h100; end
      6: op = 5;
      default: op = 2;
    endcase
    w = (longint'(1) << 31) | (longint'(3) << 20) | (bank << 17) | (addr << 4) | op;
    return w[31:0];
  endfunction

  task automatic runSeq(input int lat, input int loAt, input int hiAt,
                        input logic [12:0] m0, input logic [12:0] m1,
                        input logic [12:0] m2, input logic [12:0] m3,
                        input logic [15:0] refiA, input logic [15:0] refiB,
                        input bit midStart);
    int base, nAcc, gapN, trHigh, tcnt, inTrainCmd, zeroBad, trackBad, iter, midAt, expHigh;
    bit sawTrain;
    nAcc = 0; gapN = 0; trHigh = 0; tcnt = 0; inTrainCmd = 0;
    zeroBad = 0; trackBad = 0; iter = 0; midAt = -1; sawTrain = 0;
    mr0Val = m0; mr1Val = m1; mr2Val = m2; mr3Val = m3;
    portLat = lat;
    refiIn = refiA;
    base = logN;
    @(negedge clk); #1;
    startPulse = 1'b1;
    while (iter < 3000) begin
      @(negedge clk); #1;
      if (iter == 0) begin
        startPulse = 1'b0;
        chk(!seqDone && !seqErr && cmdValid, "R9", "run begins, flags cleared",
            {seqDone, seqErr, cmdValid}, 3'b001);
      end
      if (midAt == iter) startPulse = 1'b0;
      if (seqDone || seqErr) break;
      if (trainStart) begin
        trHigh++;
        tcnt++;
        if (!sawTrain) begin sawTrain = 1; refiIn = refiB; end
        if (cmdValid) inTrainCmd++;
      end else begin
        tcnt = 0;
      end
      trainDone = {tcnt > hiAt, tcnt > loAt};
      if ((trainStart || (cmdValid && nAcc >= 7)) && refiOut != 16'd0) zeroBad++;
      if (nAcc >= 1 && nAcc <= 6 && refiOut != refiA) trackBad++;
      if (!cmdValid && !trainStart && nAcc == 1) gapN++;
      if (cmdValid && cmdDone) nAcc++;
      if (midStart && nAcc == 3 && midAt < 0) begin
        startPulse = 1'b1;
        midAt = iter + 1;
      end
      iter++;
    end
    trainDone = 2'b00;
    expHigh = ((loAt > hiAt) ? loAt : hiAt) + 1;
    chk(seqDone && !seqErr, "R8", "run completes", {seqDone, seqErr}, 2'b10);
    if (lat == TOUT - 1)
      chk(!seqErr, "R7", "acknowledge on last allowed cycle accepted", seqErr, 0);
    chk(nAcc == 10 && (logN - base) == 10, "R3", "accepted command count", logN - base, 10);
    if (midStart)
      chk(nAcc == 10, "R9", "start during run ignored", nAcc, 10);
    for (int k = 0; k < 10; k++)
      chk(wlog[base + k] == expWord(k, m0, m1, m2, m3), "R2", "command word in order",
          wlog[base + k], expWord(k, m0, m1, m2, m3));
    chk(wlog[base + 2][19:17] == 3'd2 && wlog[base + 2][16:4] == m2 &&
        wlog[base + 2][3:0] == 4'd3 && wlog[base + 2][31] && wlog[base + 2][21:20] == 2'b11,
        "R1", "field layout of first mode write", wlog[base + 2], expWord(2, m0, m1, m2, m3));
    chk(wlog[base + 5][12] == 1'b1, "R1", "DLL reset at address bit 8", wlog[base + 5][12], 1);
    chk(gapN == GAP, "R4", "idle cycles after deselect", gapN, GAP);
    chk(trHigh == expHigh, "R5", "training start length", trHigh, expHigh);
    chk(inTrainCmd == 0, "R5", "no command during training", inTrainCmd, 0);
    chk(zeroBad == 0, "R6", "interval parked at zero", zeroBad, 0);
    chk(trackBad == 0, "R6", "interval tracks input before training", trackBad, 0);
    chk(refiOut == refiA, "R6", "saved interval restored", refiOut, refiA);
    for (int h = 0; h < 3; h++) begin
      @(negedge clk); #1;
      chk(seqDone && !cmdValid && refiOut == refiA, "R8", "done and interval held",
          {seqDone, cmdValid, refiOut}, {1'b1, 1'b0, refiA});
    end
  endtask

  task automatic runFault();
    int iter, validN;
    iter = 0; validN = 0;
    portLat = TOUT;
    @(negedge clk); #1;
    startPulse = 1'b1;
    while (iter < 500) begin
      @(negedge clk); #1;
      if (iter == 0) startPulse = 1'b0;
      if (seqErr) break;
      if (cmdValid) validN++;
      iter++;
    end
    chk(seqErr, "R7", "halt on missing acknowledge", seqErr, 1);
    chk(validN == TOUT, "R7", "offer cycles before halt", validN, TOUT);
    for (int h = 0; h < 3; h++) begin
      @(negedge clk); #1;
      chk(seqErr && !cmdValid && !seqDone && !trainStart, "R7", "halted and quiet",
          {seqErr, cmdValid, seqDone, trainStart}, 4'b1000);
    end
    refiIn = 16'h0abc;
    @(negedge clk); #1;
    @(negedge clk); #1;
    chk(refiOut == 16'h0abc, "R6", "interval tracks input while halted", refiOut, 16'h0abc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cmdValid == 0 && cmdWord == 0 && trainStart == 0 && seqDone == 0 &&
        seqErr == 0 && refiOut == 0, "R10", "reset outputs",
        {cmdValid, trainStart, seqDone, seqErr, refiOut}, 0);
    rstN = 1'b1;
    refiIn = 16'd55;
    repeat (3) begin @(negedge clk); #1; end
    chk(refiOut == 16'd55 && !cmdValid && cmdWord == 0, "R6", "idle tracking, no command",
        refiOut, 55);

    for (int lat = 0; lat < TOUT; lat++) begin
      int lo, hi;
      lo = lat % 3;
      hi = lo + 2;
      if (lat % 2 == 1) begin lo = hi + 2; end
      runSeq(lat, lo, hi,
             13'(lat * 13'h151 + 13'h021), 13'(13'h1fff - lat * 7),
             13'(lat * 13'h0a3 + 5), 13'(lat + 13'h0808),
             16'(100 + lat * 37), 16'(900 + lat), lat == 2);
    end

    runFault();
    runSeq(1, 0, 1, 13'h0420, 13'h0042, 13'h0018, 13'h0000, 16'h1234, 16'h4321, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule